// File: doc/BRIEF.md
# Banked Register Access Decoder

This block sits behind a serial configuration port and turns each 7-bit register address into a target and a physical location. Addresses with the top bit clear form a 64-entry window. A bank-select register steers that window. In bank 0 the first sixteen offsets land in configuration RAM. Every other bank/offset pair lands in an external memory page at bank×64+offset. Addresses with the top bit set are direct. They hold the bank-select register, a protection register, and an 8-byte read-only identification area at the top of the map. The identification bytes come from a constant word.

The decoder also tracks whether nonvolatile memory is attached. Without it, the decoder answers only the bank-0 configuration RAM and the identification area. A magic write into the identification area switches the port to a short timeout. Writing offset 0x00 of the configuration RAM starts an internal reset, which drops that override again. Two protection bits block writes to chosen targets. Each request gets one registered response, one cycle later.

Top module: `banked_reg_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_ack, short_tmo and cfg_rst are 0, the bank select is 0 and the protection bits are 0.
- R2: When the bank select is 0, window offsets 0x00–0x0F answer with rsp_ack=1, rsp_tgt=1 (configuration RAM) and rsp_mem_addr equal to the offset, whether or not nonvolatile memory is present.
- R3: Any other window access answers with rsp_tgt=2 (external memory) and rsp_mem_addr = bank×64 + offset.
- R4: Address 0x40 is the bank select (rsp_tgt=3). Only its low 4 bits are kept. A read returns the kept value zero-extended in rsp_rdata. The bank select changes only on an accepted write to 0x40.
- R5: A read of 0x78–0x7F answers with rsp_tgt=4 and returns byte (address−0x78) of the identification word. Byte 0 is the least significant byte.
- R6: A write to 0x78–0x7F other than 0x7C answers with rsp_ack=1, rsp_err=1 and rsp_wen=0.
- R7: A write of 0x07 to 0x7C sets short_tmo and answers rsp_wen=1. A write of any other value to 0x7C clears short_tmo.
- R8: While nvm_present is 0, external-memory accesses and addresses 0x40–0x77 get no answer: rsp_ack=0 and rsp_tgt=0.
- R9: Addresses 0x42–0x77 never get an answer.
- R10: Address 0x41 holds the two protection bits. A write ORs data bits [1:0] into them, so a bit is never cleared. Bit 0 blocks writes to external memory. Bit 1 blocks writes to configuration RAM and to the bank select. A blocked write answers rsp_err=1 and rsp_wen=0, and it changes no state. Reads stay allowed. A read of 0x41 returns the bits.
- R11: An accepted write to configuration RAM offset 0x00 pulses cfg_rst for one cycle and clears short_tmo. A read of that offset does neither.
- R12: rsp_valid is 1 exactly in the cycle after each cycle with req_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nvm_present | input | 1 | Nonvolatile memory attached |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_ack | output | 1 | Decoder answers this access |
| rsp_err | output | 1 | Write refused (read-only or protected) |
| rsp_wen | output | 1 | Write carried out at the target |
| rsp_tgt | output | 3 | 0 none, 1 config RAM, 2 external memory, 3 internal register, 4 identification ROM |
| rsp_mem_addr | output | 10 | RAM offset or external memory address |
| rsp_rdata | output | 8 | Read data for internal registers and identification bytes |
| short_tmo | output | 1 | Short protocol timeout selected |
| cfg_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The hardest cases to reach are the ones that need several earlier writes in the right order.

- An internal reset can only be observed with the bank select back at 0 and the timeout override already set. The stimulus therefore writes the bank select to 0, then arms the override, then does a harmless read of offset 0x00 before the real write.
- Protection refusals need the bits raised one at a time. A clearing write to 0x41 in between shows that the bits are sticky. The refused bank-select write is followed by a read-back, which shows that no state moved.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_RAM  = 3'd1,
        TGT_EXT  = 3'd2,
        TGT_REG  = 3'd3,
        TGT_ROM  = 3'd4
    } tgt_e;

    typedef enum logic [2:0] {
        RG_WIN_RAM,
        RG_WIN_EXT,
        RG_BANK,
        RG_PROT,
        RG_ID,
        RG_HOLE
    } region_e;
endpackage

// File: rtl/bank_dec_region.sv
module bank_dec_region
    import bank_dec_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BANK_W    = 4,
    parameter int RAM_DEPTH = 16,
    parameter int ID_BYTES  = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 7'h41,
    localparam int OFF_W = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output region_e           region,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((2 ** ADDR_W) - ID_BYTES);

    assign off = addr[OFF_W-1:0];

    always_comb begin
        if (!addr[ADDR_W-1]) begin
            region = (bank == '0 && int'(off) < RAM_DEPTH) ? RG_WIN_RAM : RG_WIN_EXT;
        end else if (addr == BANK_ADDR) begin
            region = RG_BANK;
        end else if (addr == PROT_ADDR) begin
            region = RG_PROT;
        end else if (addr >= ID_BASE) begin
            region = RG_ID;
        end else begin
            region = RG_HOLE;
        end
    end
endmodule

// File: rtl/bank_dec_idrom.sv
module bank_dec_idrom #(
    parameter int ID_BYTES = 8,
    parameter logic [8*ID_BYTES-1:0] ID_WORD = 64'h5A17_0342_C08E_6B1D,
    localparam int IDX_W = $clog2(ID_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    logic [7:0] rom [ID_BYTES];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
        assign rom[g] = ID_WORD[8*g +: 8];
    end

    assign byte_o = rom[idx];
endmodule

// File: rtl/banked_reg_decoder.sv
module banked_reg_decoder
    import bank_dec_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int BANK_W    = 4,
    parameter int PROT_W    = 2,
    parameter int RAM_DEPTH = 16,
    parameter int ID_BYTES  = 8,
    parameter logic [8*ID_BYTES-1:0] ID_WORD = 64'h5A17_0342_C08E_6B1D,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 7'h41,
    parameter logic [ADDR_W-1:0] TMO_ADDR  = 7'h7C,
    parameter logic [DATA_W-1:0] TMO_MAGIC = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nvm_present,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [6:0]  req_addr,
    input  logic [7:0]  req_wdata,
    output logic        rsp_valid,
    output logic        rsp_ack,
    output logic        rsp_err,
    output logic        rsp_wen,
    output logic [2:0]  rsp_tgt,
    output logic [9:0]  rsp_mem_addr,
    output logic [7:0]  rsp_rdata,
    output logic        short_tmo,
    output logic        cfg_rst
);
    localparam int OFF_W  = ADDR_W - 1;
    localparam int MEM_AW = BANK_W + OFF_W;
    localparam int IDX_W  = $clog2(ID_BYTES);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PROT_W-1:0] prot;
        logic              tmo;
        logic              valid;
        logic              ack;
        logic              err;
        logic              wen;
        logic              crst;
        tgt_e              tgt;
        logic [MEM_AW-1:0] maddr;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t            st_d, st_q;
    region_e           region;
    logic [OFF_W-1:0]  off;
    logic [7:0]        id_byte;

    bank_dec_region #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RAM_DEPTH(RAM_DEPTH),
        .ID_BYTES(ID_BYTES), .BANK_ADDR(BANK_ADDR), .PROT_ADDR(PROT_ADDR)
    ) u_region (
        .addr(req_addr), .bank(st_q.bank), .region(region), .off(off)
    );

    bank_dec_idrom #(.ID_BYTES(ID_BYTES), .ID_WORD(ID_WORD)) u_idrom (
        .idx(req_addr[IDX_W-1:0]), .byte_o(id_byte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.ack   = 1'b0;
        st_d.err   = 1'b0;
        st_d.wen   = 1'b0;
        st_d.crst  = 1'b0;
        st_d.tgt   = TGT_NONE;
        st_d.maddr = '0;
        st_d.rdata = '0;
        if (req_valid) begin
            unique case (region)
                RG_WIN_RAM: begin
                    st_d.ack   = 1'b1;
                    st_d.tgt   = TGT_RAM;
                    st_d.maddr = MEM_AW'(off);
                    if (req_write) begin
                        if (st_q.prot[1]) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.wen = 1'b1;
                            if (off == '0) begin
                                st_d.crst = 1'b1;
                                st_d.tmo  = 1'b0;
                            end
                        end
                    end
                end
                RG_WIN_EXT: if (nvm_present) begin
                    st_d.ack   = 1'b1;
                    st_d.tgt   = TGT_EXT;
                    st_d.maddr = {st_q.bank, off};
                    if (req_write) begin
                        st_d.err = st_q.prot[0];
                        st_d.wen = !st_q.prot[0];
                    end
                end
                RG_BANK: if (nvm_present) begin
                    st_d.ack = 1'b1;
                    st_d.tgt = TGT_REG;
                    if (req_write) begin
                        if (st_q.prot[1]) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.wen  = 1'b1;
                            st_d.bank = req_wdata[BANK_W-1:0];
                        end
                    end else begin
                        st_d.rdata = DATA_W'(st_q.bank);
                    end
                end
                RG_PROT: if (nvm_present) begin
                    st_d.ack = 1'b1;
                    st_d.tgt = TGT_REG;
                    if (req_write) begin
                        st_d.wen  = 1'b1;
                        st_d.prot = st_q.prot | req_wdata[PROT_W-1:0];
                    end else begin
                        st_d.rdata = DATA_W'(st_q.prot);
                    end
                end
                RG_ID: begin
                    st_d.ack = 1'b1;
                    st_d.tgt = TGT_ROM;
                    if (req_write) begin
                        if (req_addr == TMO_ADDR) begin
                            st_d.wen = 1'b1;
                            st_d.tmo = (req_wdata == TMO_MAGIC);
                        end else begin
                            st_d.err = 1'b1;
                        end
                    end else begin
                        st_d.rdata = id_byte;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.valid;
    assign rsp_ack      = st_q.ack;
    assign rsp_err      = st_q.err;
    assign rsp_wen      = st_q.wen;
    assign rsp_tgt      = st_q.tgt;
    assign rsp_mem_addr = st_q.maddr;
    assign rsp_rdata    = st_q.rdata;
    assign short_tmo    = st_q.tmo;
    assign cfg_rst      = st_q.crst;

    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_wen && !rsp_ack));
    p_nvm_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !nvm_present && region == RG_WIN_EXT) |=> !rsp_ack);
    p_hole_silence_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && region == RG_HOLE) |=> (!rsp_ack && rsp_tgt == 3'd0));
    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_write) |-> $stable(st_q.bank));
    p_prot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot & $past(st_q.prot)) == $past(st_q.prot));
    p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ack && !rsp_wen));
    p_reset_clears_tmo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst |-> (!short_tmo && rsp_tgt == 3'd1));
endmodule

// File: tb/sim_banked_reg_decoder.sv
module sim_banked_reg_decoder;
    localparam logic [63:0] IDW = 64'h5A17_0342_C08E_6B1D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nvm_present = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic rsp_valid, rsp_ack, rsp_err, rsp_wen, short_tmo, cfg_rst;
    logic [2:0] rsp_tgt;
    logic [9:0] rsp_mem_addr;
    logic [7:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_reg_decoder #(.ID_WORD(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .nvm_present(nvm_present),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_err(rsp_err), .rsp_wen(rsp_wen), .rsp_tgt(rsp_tgt),
        .rsp_mem_addr(rsp_mem_addr), .rsp_rdata(rsp_rdata),
        .short_tmo(short_tmo), .cfg_rst(cfg_rst)
    );

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
        logic [7:0] wdata;
        logic       nvm;
        logic       ack;
        logic       err;
        logic       wen;
        logic [2:0] tgt;
        logic [9:0] maddr;
        logic [7:0] rdata;
        logic       tmo;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'h05, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 10'h005, 8'h00, 1'b0},
        '{1'b1, 7'h0F, 8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 10'h00F, 8'h00, 1'b0},
        '{1'b0, 7'h10, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 10'h010, 8'h00, 1'b0},
        '{1'b1, 7'h40, 8'h03, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 10'h000, 8'h00, 1'b0},
        '{1'b0, 7'h40, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 10'h000, 8'h03, 1'b0},
        '{1'b0, 7'h05, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 10'h0C5, 8'h00, 1'b0},
        '{1'b1, 7'h3F, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 10'h0FF, 8'h00, 1'b0},
        '{1'b0, 7'h7A, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 10'h000, 8'h8E, 1'b0},
        '{1'b1, 7'h79, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 10'h000, 8'h00, 1'b0},
        '{1'b1, 7'h7C, 8'h07, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 10'h000, 8'h00, 1'b1},
        '{1'b0, 7'h50, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 10'h000, 8'h00, 1'b1},
        '{1'b0, 7'h05, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'h000, 8'h00, 1'b1},
        '{1'b0, 7'h7F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 10'h000, 8'h5A, 1'b1},
        '{1'b0, 7'h40, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 10'h000, 8'h00, 1'b1},
        '{1'b1, 7'h40, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 10'h000, 8'h00, 1'b1},
        '{1'b0, 7'h03, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 10'h003, 8'h00, 1'b1},
        '{1'b1, 7'h7C, 8'h05, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 10'h000, 8'h00, 1'b0},
        '{1'b1, 7'h7C, 8'h07, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 10'h000, 8'h00, 1'b1},
        '{1'b1, 7'h00, 8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 10'h000, 8'h00, 1'b0},
        '{1'b1, 7'h40, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 10'h000, 8'h00, 1'b0},
        '{1'b0, 7'h3F, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 10'h3FF, 8'h00, 1'b0},
        '{1'b1, 7'h40, 8'hF2, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 10'h000, 8'h00, 1'b0},
        '{1'b0, 7'h40, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 10'h000, 8'h02, 1'b0},
        '{1'b0, 7'h7C, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 10'h000, 8'h42, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [6:0] a,
                        input logic [7:0] d, input logic nvm);
        req_write   = wr;
        req_addr    = a;
        req_wdata   = d;
        nvm_present = nvm;
        req_valid   = 1'b1;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.tgt == 3'd1) return "R2";
        if (v.tgt == 3'd2) return "R3";
        if (v.tgt == 3'd3) return "R4";
        if (v.tgt == 3'd4) return v.err ? "R6" : (v.wr ? "R7" : "R5");
        return v.nvm ? "R9" : "R8";
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "rsp_ack", 32'(rsp_ack), 32'd0);
        chk("R1", "short_tmo", 32'(short_tmo), 32'd0);
        chk("R1", "cfg_rst", 32'(cfg_rst), 32'd0);
        xfer(1'b0, 7'h40, 8'h00, 1'b1);
        chk("R1", "bank readback", 32'(rsp_rdata), 32'd0);
        xfer(1'b0, 7'h41, 8'h00, 1'b1);
        chk("R1", "prot readback", 32'(rsp_rdata), 32'd0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].nvm);
            chk("R12", $sformatf("vec%0d valid", i), 32'(rsp_valid), 32'd1);
            chk(tag_of(VEC[i]), $sformatf("vec%0d ack", i), 32'(rsp_ack), 32'(VEC[i].ack));
            chk(tag_of(VEC[i]), $sformatf("vec%0d err", i), 32'(rsp_err), 32'(VEC[i].err));
            chk(tag_of(VEC[i]), $sformatf("vec%0d wen", i), 32'(rsp_wen), 32'(VEC[i].wen));
            chk(tag_of(VEC[i]), $sformatf("vec%0d tgt", i), 32'(rsp_tgt), 32'(VEC[i].tgt));
            chk(tag_of(VEC[i]), $sformatf("vec%0d maddr", i), 32'(rsp_mem_addr), 32'(VEC[i].maddr));
            chk(tag_of(VEC[i]), $sformatf("vec%0d rdata", i), 32'(rsp_rdata), 32'(VEC[i].rdata));
            chk("R7", $sformatf("vec%0d tmo", i), 32'(short_tmo), 32'(VEC[i].tmo));
        end

        // R11 internal reset
        xfer(1'b1, 7'h40, 8'h00, 1'b1);
        xfer(1'b1, 7'h7C, 8'h07, 1'b1);
        chk("R7", "override armed", 32'(short_tmo), 32'd1);
        xfer(1'b0, 7'h00, 8'h00, 1'b1);
        chk("R11", "read 0x00 no pulse", 32'(cfg_rst), 32'd0);
        chk("R11", "read 0x00 keeps tmo", 32'(short_tmo), 32'd1);
        xfer(1'b1, 7'h00, 8'h5C, 1'b1);
        chk("R11", "write 0x00 pulse", 32'(cfg_rst), 32'd1);
        chk("R11", "write 0x00 clears tmo", 32'(short_tmo), 32'd0);
        idle();
        chk("R11", "pulse one cycle", 32'(cfg_rst), 32'd0);
        chk("R12", "idle no valid", 32'(rsp_valid), 32'd0);

        // R10 protection
        xfer(1'b1, 7'h40, 8'h01, 1'b1);
        xfer(1'b1, 7'h41, 8'h01, 1'b1);
        chk("R10", "prot write wen", 32'(rsp_wen), 32'd1);
        xfer(1'b1, 7'h05, 8'hAA, 1'b1);
        chk("R10", "ext blocked err", 32'(rsp_err), 32'd1);
        chk("R10", "ext blocked wen", 32'(rsp_wen), 32'd0);
        chk("R10", "ext blocked maddr", 32'(rsp_mem_addr), 32'h045);
        xfer(1'b0, 7'h05, 8'h00, 1'b1);
        chk("R10", "ext read allowed", 32'(rsp_err), 32'd0);
        xfer(1'b1, 7'h41, 8'h00, 1'b1);
        xfer(1'b0, 7'h41, 8'h00, 1'b1);
        chk("R10", "prot sticky", 32'(rsp_rdata), 32'h01);
        xfer(1'b1, 7'h40, 8'h00, 1'b1);
        chk("R10", "bank write while bit0", 32'(rsp_wen), 32'd1);
        xfer(1'b1, 7'h02, 8'h44, 1'b1);
        chk("R10", "ram write while bit0", 32'(rsp_wen), 32'd1);
        xfer(1'b1, 7'h41, 8'h02, 1'b1);
        xfer(1'b0, 7'h41, 8'h00, 1'b1);
        chk("R10", "prot both bits", 32'(rsp_rdata), 32'h03);
        xfer(1'b1, 7'h02, 8'h44, 1'b1);
        chk("R10", "ram blocked err", 32'(rsp_err), 32'd1);
        chk("R10", "ram blocked wen", 32'(rsp_wen), 32'd0);
        xfer(1'b1, 7'h40, 8'h05, 1'b1);
        chk("R10", "bank blocked err", 32'(rsp_err), 32'd1);
        xfer(1'b0, 7'h40, 8'h00, 1'b1);
        chk("R10", "bank unchanged", 32'(rsp_rdata), 32'h00);
        xfer(1'b0, 7'h02, 8'h00, 1'b1);
        chk("R10", "ram read allowed", 32'(rsp_ack & ~rsp_err), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule